// File: doc/BRIEF.md
# Codec Response Ring Writer

This block sits between a codec link and system memory and files every 32-bit codec response that arrives. Each response carries a 4-bit codec address and a flag that marks it as solicited or unsolicited. There are two places a response can go. When software has a single command outstanding through the immediate path, the response goes into an immediate response register. Otherwise it becomes a two-word entry in a 256-entry circular ring in memory: the response word first, then a tag word. If ring transfers are turned off, the response is thrown away.

The block owns the 8-bit ring write pointer, the control register (interrupt enable, ring transfer enable), the response threshold, the running response count and the interrupt status bit. At most one ring entry is in flight at a time. While an entry is being written, `rsp_ready` stays low. After the second word of an entry is accepted, the block updates the write pointer and the count. It then sets the interrupt status if the count has reached the threshold, or if the command ring is empty, provided interrupts are enabled.

When software clears the interrupt status, the block resets the count and sends a one-cycle restart pulse so the command fetcher resumes.

Top module: `resp_ring_writer`

## Requirements
- R1: After reset the write pointer, response count, interrupt status, `resp_irq`, `fetch_restart`, `mem_req` and immediate status are all zero, and `rsp_ready` is 1.
- R2: A response accepted while immediate busy (imm_stat_o bit 0) is 1 has the following effects: its data is stored in `imm_resp_o`, busy is cleared, valid (bit 1) is set, the codec address is placed in bits 7:4, bits 3:2 read 0, and no memory write occurs. A pulse on `imm_issue` sets busy and clears valid.
- R3: A response accepted while busy is 0 and ring transfer enable (ctl bit 1) is 0 is discarded. No memory request follows, and the pointer and count are unchanged.
- R4: The tag word of an entry holds the codec address in bits 3:0, holds 1 in bit 4 for an unsolicited response and 0 for a solicited one, and holds zero in every other bit.
- R5: For each ring entry the pointer is first advanced by one modulo 256, so 255 is followed by 0. The response word is then written to base + 8*pointer, and after it the tag word is written to base + 8*pointer + 4.
- R6: Each ring entry adds one to the count, which wraps modulo 256. When the new count equals the threshold and interrupt enable (ctl bit 0) is 1, status bit 0 and `resp_irq` become 1.
- R7: If the command ring is empty when an entry completes and interrupt enable is 1, status bit 0 is set even below the threshold. If interrupt enable is 0, no entry sets the status.
- R8: A pointer-register write with bit 15 set forces the write pointer to 0. The next entry then goes to index 1.
- R9: A status write with bit 0 = 1 while the status is set clears the status and the count, and raises `fetch_restart` for exactly the next cycle. Writing bit 0 = 1 while the status is clear, or writing 0, has no effect.
- R10: `mem_req` with its address and data is held stable until `mem_ack`. The pointer and count do not change until the tag word is accepted, and `rsp_ready` is 0 while an entry is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_valid | input | 1 | Codec response present |
| rsp_ready | output | 1 | Block can accept a response |
| rsp_data | input | 32 | Response word |
| rsp_cad | input | 4 | Codec address of the response |
| rsp_unsol | input | 1 | 1 for an unsolicited response |
| imm_issue | input | 1 | Immediate command issued; sets busy |
| imm_resp_o | output | 32 | Immediate response register |
| imm_stat_o | output | 8 | Immediate status: bit 0 busy, bit 1 valid, bits 7:4 codec address |
| ring_base | input | 64 | Byte base address of the response ring |
| wp_wr | input | 1 | Write strobe for the pointer register |
| wp_wdata | input | 16 | Pointer register write data; bit 15 is the pointer reset |
| wp_o | output | 8 | Ring write pointer |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data: bit 0 interrupt enable, bit 1 ring transfer enable |
| ctl_o | output | 8 | Control register |
| thr_wr | input | 1 | Write strobe for the threshold |
| thr_wdata | input | 8 | Threshold value (0 acts as 256) |
| sts_wr | input | 1 | Write strobe for the status register |
| sts_wdata | input | 8 | Status write data; bit 0 is write-one-to-clear |
| sts_o | output | 8 | Status register; bit 0 is the response interrupt |
| resp_count_o | output | 8 | Responses written since the last clear |
| cmd_ring_empty | input | 1 | Command ring has no pending command |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write accepted this cycle |
| mem_addr | output | 64 | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| resp_irq | output | 1 | Response interrupt |
| fetch_restart | output | 1 | One-cycle pulse to restart command fetching |

## Verification
The assertions rely on four conditions holding on the inputs. Register writes and `imm_issue` arrive only while no ring entry is in flight. `imm_issue` never falls in the same cycle as an accepted response. `cmd_ring_empty` keeps its value while an entry is being written. `rsp_valid` is raised only when `rsp_ready` is high. The bench meets all four by driving one response at a time from a task, serving both memory words with randomly delayed `mem_ack` before it touches any register, and setting `cmd_ring_empty` together with the response.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  // fixed field positions that software decodes
  localparam int CAD_W         = 4;
  localparam int CTL_IE_BIT    = 0;
  localparam int CTL_DMA_BIT   = 1;
  localparam int STS_INT_BIT   = 0;
  localparam int WP_RST_BIT    = 15;
  localparam int IMM_BUSY_BIT  = 0;
  localparam int IMM_VALID_BIT = 1;
  localparam int IMM_CAD_LSB   = 4;
  localparam int TAG_UNSOL_BIT = 4;

  typedef enum logic [1:0] {
    RW_IDLE = 2'd0,
    RW_DATA = 2'd1,
    RW_TAG  = 2'd2
  } rw_state_e;
endpackage

// File: rtl/rrw_rst_sync.sv
module rrw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rrw_imm_path.sv
module rrw_imm_path
  import rrw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [CAD_W-1:0]  cap_cad,
  output logic              busy,
  output logic [DATA_W-1:0] imm_resp,
  output logic [7:0]        imm_stat
);
  logic              busy_q, busy_d;
  logic              valid_q, valid_d;
  logic [CAD_W-1:0]  cad_q;
  logic [DATA_W-1:0] resp_q;
  logic              stat_en;

  always_comb begin
    busy_d  = busy_q;
    valid_d = valid_q;
    stat_en = cap | issue;
    if (cap) begin
      busy_d  = 1'b0;
      valid_d = 1'b1;
    end else if (issue) begin
      busy_d  = 1'b1;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (stat_en) begin
      busy_q  <= busy_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= '0;
      cad_q  <= '0;
    end else if (cap) begin
      resp_q <= cap_data;
      cad_q  <= cap_cad;
    end
  end

  always_comb begin
    imm_stat                                = '0;
    imm_stat[IMM_BUSY_BIT]                  = busy_q;
    imm_stat[IMM_VALID_BIT]                 = valid_q;
    imm_stat[IMM_CAD_LSB +: CAD_W]          = cad_q;
  end

  assign busy     = busy_q;
  assign imm_resp = resp_q;

  // R2
  imm_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (imm_stat[IMM_VALID_BIT] && !imm_stat[IMM_BUSY_BIT] &&
             imm_stat[IMM_CAD_LSB +: CAD_W] == $past(cap_cad) &&
             imm_resp == $past(cap_data)));
endmodule

// File: rtl/rrw_ring_engine.sv
module rrw_ring_engine
  import rrw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic [CAD_W-1:0]  start_cad,
  input  logic              start_unsol,
  input  logic [ADDR_W-1:0] base,
  input  logic              wp_rst,
  input  logic              mem_ack,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [PTR_W-1:0]  wp,
  output logic              commit
);
  localparam int WORD_BYTES  = DATA_W / 8;
  localparam int ENTRY_SHIFT = $clog2(2 * WORD_BYTES);
  localparam int OFF_W       = PTR_W + ENTRY_SHIFT;

  rw_state_e         st_q, st_d;
  logic [PTR_W-1:0]  wp_q, wp_d, nptr_q;
  logic [PTR_W-1:0]  wp_inc;
  logic [DATA_W-1:0] data_q, tag_q, tag_w;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [OFF_W-1:0]  ent_off;
  logic [ADDR_W-1:0] ent_addr;
  logic              cap_en, step_en, wp_en;

  assign wp_inc   = wp_q + PTR_W'(1);
  assign ent_off  = {wp_inc, {ENTRY_SHIFT{1'b0}}};
  assign ent_addr = base + ADDR_W'(ent_off);

  always_comb begin
    tag_w                   = '0;
    tag_w[CAD_W-1:0]        = start_cad;
    tag_w[TAG_UNSOL_BIT]    = start_unsol;
  end

  // next state
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    cap_en  = 1'b0;
    step_en = 1'b0;
    commit  = 1'b0;
    case (st_q)
      RW_IDLE: begin
        if (start) begin
          st_d   = RW_DATA;
          cap_en = 1'b1;
          addr_d = ent_addr;
        end
      end
      RW_DATA: begin
        if (mem_ack) begin
          st_d    = RW_TAG;
          step_en = 1'b1;
          addr_d  = addr_q + ADDR_W'(WORD_BYTES);
        end
      end
      RW_TAG: begin
        if (mem_ack) begin
          st_d   = RW_IDLE;
          commit = 1'b1;
        end
      end
      default: st_d = RW_IDLE;
    endcase
  end

  always_comb begin
    wp_en = wp_rst | commit;
    wp_d  = wp_rst ? '0 : nptr_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RW_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tag_q  <= '0;
      nptr_q <= '0;
    end else if (cap_en) begin
      data_q <= start_data;
      tag_q  <= tag_w;
      nptr_q <= wp_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (cap_en | step_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
    end else if (wp_en) begin
      wp_q <= wp_d;
    end
  end

  assign busy     = (st_q != RW_IDLE);
  assign mem_req  = busy;
  assign mem_addr = addr_q;
  assign mem_data = (st_q == RW_TAG) ? tag_q : data_q;
  assign wp       = wp_q;

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  // R5
  tag_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RW_DATA && mem_ack) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

  // R4
  tag_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RW_TAG) |-> (mem_data[DATA_W-1:TAG_UNSOL_BIT+1] == '0));

  // R8
  wp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q != $past(wp_q)) |-> ((wp_q == $past(wp_q) + PTR_W'(1)) || (wp_q == '0)));
endmodule

// File: rtl/rrw_irq_ctrl.sv
module rrw_irq_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_ie_w,
  input  logic             ctl_dma_w,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_w,
  input  logic             sts_wr,
  input  logic             sts_w1,
  input  logic             commit,
  input  logic             cmd_empty,
  output logic             ie,
  output logic             dma_en,
  output logic [CNT_W-1:0] count,
  output logic             sts_int,
  output logic             fetch_restart
);
  logic             ie_q, dma_q, sts_q, sts_d, restart_q;
  logic [CNT_W-1:0] thr_q, cnt_q, cnt_base, cnt_d;
  logic             clr, hit, cnt_en, sts_en;

  always_comb begin
    clr      = sts_wr & sts_w1 & sts_q;
    cnt_base = clr ? '0 : cnt_q;
    cnt_d    = commit ? cnt_base + CNT_W'(1) : cnt_base;
    cnt_en   = clr | commit;
    hit      = commit & ie_q & ((cnt_d == thr_q) | cmd_empty);
    sts_en   = clr | hit;
    sts_d    = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      dma_q <= 1'b0;
    end else if (ctl_wr) begin
      ie_q  <= ctl_ie_w;
      dma_q <= ctl_dma_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (thr_wr) begin
      thr_q <= thr_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
    end else begin
      restart_q <= clr;
    end
  end

  assign ie            = ie_q;
  assign dma_en        = dma_q;
  assign count         = cnt_q;
  assign sts_int       = sts_q;
  assign fetch_restart = restart_q;

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_w1 && sts_q && !commit) |=> (fetch_restart && !sts_q && cnt_q == '0));

  // R9
  restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_restart |-> $past(sts_q));

  // R7
  sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> ($past(commit) && $past(ie_q)));
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
  import rrw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [CAD_W-1:0]  rsp_cad,
  input  logic              rsp_unsol,
  input  logic              imm_issue,
  output logic [DATA_W-1:0] imm_resp_o,
  output logic [7:0]        imm_stat_o,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              wp_wr,
  input  logic [15:0]       wp_wdata,
  output logic [PTR_W-1:0]  wp_o,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_o,
  input  logic              thr_wr,
  input  logic [CNT_W-1:0]  thr_wdata,
  input  logic              sts_wr,
  input  logic [7:0]        sts_wdata,
  output logic [7:0]        sts_o,
  output logic [CNT_W-1:0]  resp_count_o,
  input  logic              cmd_ring_empty,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              resp_irq,
  output logic              fetch_restart
);
  logic rst_sync_n;
  logic ring_busy, imm_busy, dma_en, ie, sts_int, commit;
  logic accept, to_imm, to_ring, wp_rst;
  logic unused_wdata;

  assign unused_wdata = ^{wp_wdata[WP_RST_BIT-1:0], ctl_wdata[7:2], sts_wdata[7:1]};

  rrw_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign rsp_ready = ~ring_busy;
  assign accept    = rsp_valid & rsp_ready;
  assign to_imm    = accept & imm_busy;
  assign to_ring   = accept & ~imm_busy & dma_en;
  assign wp_rst    = wp_wr & wp_wdata[WP_RST_BIT];

  rrw_imm_path #(.DATA_W(DATA_W)) imm_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .issue    (imm_issue),
    .cap      (to_imm),
    .cap_data (rsp_data),
    .cap_cad  (rsp_cad),
    .busy     (imm_busy),
    .imm_resp (imm_resp_o),
    .imm_stat (imm_stat_o)
  );

  rrw_ring_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) ring_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (to_ring),
    .start_data  (rsp_data),
    .start_cad   (rsp_cad),
    .start_unsol (rsp_unsol),
    .base        (ring_base),
    .wp_rst      (wp_rst),
    .mem_ack     (mem_ack),
    .busy        (ring_busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .wp          (wp_o),
    .commit      (commit)
  );

  rrw_irq_ctrl #(.CNT_W(CNT_W)) irq_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .ctl_wr        (ctl_wr),
    .ctl_ie_w      (ctl_wdata[CTL_IE_BIT]),
    .ctl_dma_w     (ctl_wdata[CTL_DMA_BIT]),
    .thr_wr        (thr_wr),
    .thr_w         (thr_wdata),
    .sts_wr        (sts_wr),
    .sts_w1        (sts_wdata[STS_INT_BIT]),
    .commit        (commit),
    .cmd_empty     (cmd_ring_empty),
    .ie            (ie),
    .dma_en        (dma_en),
    .count         (resp_count_o),
    .sts_int       (sts_int),
    .fetch_restart (fetch_restart)
  );

  always_comb begin
    ctl_o              = '0;
    ctl_o[CTL_IE_BIT]  = ie;
    ctl_o[CTL_DMA_BIT] = dma_en;
    sts_o              = '0;
    sts_o[STS_INT_BIT] = sts_int;
  end

  assign resp_irq = sts_int;

  // R3
  drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && !imm_busy && !dma_en) |=> !mem_req);

  // R2
  imm_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    to_imm |=> !mem_req);
endmodule

// File: tb/resp_ring_writer_tb_top.sv
module resp_ring_writer_tb_top;
  localparam logic [63:0] RING_BASE = 64'h0000_0012_3456_7000;

  logic        clk, rst_n;
  logic        rsp_valid, rsp_ready, rsp_unsol;
  logic [31:0] rsp_data;
  logic [3:0]  rsp_cad;
  logic        imm_issue;
  logic [31:0] imm_resp_o;
  logic [7:0]  imm_stat_o;
  logic [63:0] ring_base;
  logic        wp_wr;
  logic [15:0] wp_wdata;
  logic [7:0]  wp_o;
  logic        ctl_wr;
  logic [7:0]  ctl_wdata, ctl_o;
  logic        thr_wr;
  logic [7:0]  thr_wdata;
  logic        sts_wr;
  logic [7:0]  sts_wdata, sts_o, resp_count_o;
  logic        cmd_ring_empty;
  logic        mem_req, mem_ack;
  logic [63:0] mem_addr;
  logic [31:0] mem_data;
  logic        resp_irq, fetch_restart;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] exp_wp, exp_cnt, exp_thr;
  logic       exp_sts, exp_ie, exp_dma;

  resp_ring_writer dut_i (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_cad(rsp_cad), .rsp_unsol(rsp_unsol),
    .imm_issue(imm_issue), .imm_resp_o(imm_resp_o), .imm_stat_o(imm_stat_o),
    .ring_base(ring_base),
    .wp_wr(wp_wr), .wp_wdata(wp_wdata), .wp_o(wp_o),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_o(ctl_o),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_o(sts_o),
    .resp_count_o(resp_count_o), .cmd_ring_empty(cmd_ring_empty),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data),
    .resp_irq(resp_irq), .fetch_restart(fetch_restart)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_tag(input logic [3:0] cad, input logic unsol);
    return {27'd0, unsol, cad};
  endfunction

  function automatic logic [63:0] exp_entry_addr(input logic [7:0] idx);
    return RING_BASE + {53'd0, idx, 3'b000};
  endfunction

  task automatic wr_ctl(input logic ie, input logic dma);
    ctl_wr = 1'b1; ctl_wdata = {6'b101010, dma, ie};
    @(posedge clk); @(negedge clk);
    ctl_wr = 1'b0;
    exp_ie = ie; exp_dma = dma;
  endtask

  task automatic wr_thr(input logic [7:0] v);
    thr_wr = 1'b1; thr_wdata = v;
    @(posedge clk); @(negedge clk);
    thr_wr = 1'b0;
    exp_thr = v;
  endtask

  // writes status bit0; model and check the restart pulse
  task automatic wr_sts(input logic b);
    logic exp_rs;
    exp_rs = b & exp_sts;
    sts_wr = 1'b1; sts_wdata = {7'b1111111, b};
    @(posedge clk); @(negedge clk);
    sts_wr = 1'b0;
    if (exp_rs) begin exp_sts = 1'b0; exp_cnt = 8'd0; end
    chk("R9 restart pulse", {63'd0, fetch_restart}, {63'd0, exp_rs});
    chk("R9 status after write", {56'd0, sts_o}, {63'd0, exp_sts});
    chk("R9 count after write", {56'd0, resp_count_o}, {56'd0, exp_cnt});
    @(negedge clk);
    chk("R9 restart one cycle", {63'd0, fetch_restart}, 64'd0);
  endtask

  task automatic do_issue();
    imm_issue = 1'b1;
    @(posedge clk); @(negedge clk);
    imm_issue = 1'b0;
    chk("R2 busy after issue", {56'd0, imm_stat_o[1:0]}, 64'd1);
  endtask

  task automatic send_imm(input logic [31:0] d, input logic [3:0] cad);
    rsp_valid = 1'b1; rsp_data = d; rsp_cad = cad; rsp_unsol = 1'b0;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
    chk("R2 immediate data", {32'd0, imm_resp_o}, {32'd0, d});
    chk("R2 immediate status", {56'd0, imm_stat_o}, {56'd0, cad, 4'b0010});
    chk("R2 no memory write", {63'd0, mem_req}, 64'd0);
    chk("R2 pointer kept", {56'd0, wp_o}, {56'd0, exp_wp});
  endtask

  task automatic send_drop(input logic [31:0] d, input logic [3:0] cad);
    rsp_valid = 1'b1; rsp_data = d; rsp_cad = cad; rsp_unsol = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
    chk("R3 no request", {63'd0, mem_req}, 64'd0);
    @(negedge clk);
    chk("R3 still no request", {63'd0, mem_req}, 64'd0);
    chk("R3 pointer kept", {56'd0, wp_o}, {56'd0, exp_wp});
    chk("R3 count kept", {56'd0, resp_count_o}, {56'd0, exp_cnt});
  endtask

  task automatic send_ring(input logic [31:0] d, input logic [3:0] cad,
                           input logic unsol, input logic empty);
    logic [63:0] a0, a1;
    logic [31:0] d0, d1;
    logic [7:0]  new_wp;
    int got;
    got = 0; a0 = '0; a1 = '0; d0 = '0; d1 = '0;
    chk("R10 ready when idle", {63'd0, rsp_ready}, 64'd1);
    rsp_valid = 1'b1; rsp_data = d; rsp_cad = cad; rsp_unsol = unsol;
    cmd_ring_empty = empty;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
    while (got < 2) begin
      if (got == 1) begin
        chk("R10 pointer held mid entry", {56'd0, wp_o}, {56'd0, exp_wp});
        chk("R10 ready low mid entry", {63'd0, rsp_ready}, 64'd0);
      end
      mem_ack = ($urandom % 3) != 0;
      if (mem_req && mem_ack) begin
        if (got == 0) begin a0 = mem_addr; d0 = mem_data; end
        else begin a1 = mem_addr; d1 = mem_data; end
        got++;
      end
      @(posedge clk); @(negedge clk);
    end
    mem_ack = 1'b0;
    new_wp  = exp_wp + 8'd1;
    exp_wp  = new_wp;
    exp_cnt = exp_cnt + 8'd1;
    if (exp_ie && ((exp_cnt == exp_thr) || empty)) exp_sts = 1'b1;
    chk("R5 data address", a0, exp_entry_addr(new_wp));
    chk("R5 data word", {32'd0, d0}, {32'd0, d});
    chk("R5 tag address", a1, exp_entry_addr(new_wp) + 64'd4);
    chk("R4 tag word", {32'd0, d1}, {32'd0, exp_tag(cad, unsol)});
    chk("R5 pointer", {56'd0, wp_o}, {56'd0, exp_wp});
    chk("R6 count", {56'd0, resp_count_o}, {56'd0, exp_cnt});
    chk("R6 R7 status", {56'd0, sts_o}, {63'd0, exp_sts});
    chk("R6 interrupt", {63'd0, resp_irq}, {63'd0, exp_sts});
    chk("R10 ready after entry", {63'd0, rsp_ready}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; rsp_valid = 1'b0; rsp_data = '0; rsp_cad = '0; rsp_unsol = 1'b0;
    imm_issue = 1'b0; ring_base = RING_BASE; wp_wr = 1'b0; wp_wdata = '0;
    ctl_wr = 1'b0; ctl_wdata = '0; thr_wr = 1'b0; thr_wdata = '0;
    sts_wr = 1'b0; sts_wdata = '0; cmd_ring_empty = 1'b0; mem_ack = 1'b0;
    exp_wp = '0; exp_cnt = '0; exp_thr = '0; exp_sts = 1'b0; exp_ie = 1'b0; exp_dma = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pointer", {56'd0, wp_o}, 64'd0);
    chk("R1 count", {56'd0, resp_count_o}, 64'd0);
    chk("R1 status", {56'd0, sts_o}, 64'd0);
    chk("R1 irq", {63'd0, resp_irq}, 64'd0);
    chk("R1 restart", {63'd0, fetch_restart}, 64'd0);
    chk("R1 request", {63'd0, mem_req}, 64'd0);
    chk("R1 immediate status", {56'd0, imm_stat_o}, 64'd0);
    chk("R1 ready", {63'd0, rsp_ready}, 64'd1);

    // R6 threshold
    wr_ctl(1'b1, 1'b1);
    chk("R6 control readback", {56'd0, ctl_o}, 64'd3);
    wr_thr(8'd3);
    send_ring(32'hA000_0001, 4'h2, 1'b0, 1'b0);
    send_ring(32'hA000_0002, 4'hF, 1'b1, 1'b0);
    chk("R6 below threshold", {63'd0, resp_irq}, 64'd0);
    send_ring(32'hA000_0003, 4'h5, 1'b0, 1'b0);
    chk("R6 threshold reached", {63'd0, resp_irq}, 64'd1);

    // R9 clear and no-effect writes
    wr_sts(1'b1);
    wr_sts(1'b1);
    wr_sts(1'b0);

    // R7 command ring empty
    wr_ctl(1'b0, 1'b1);
    send_ring(32'hB000_0001, 4'h1, 1'b1, 1'b1);
    chk("R7 disabled no status", {63'd0, resp_irq}, 64'd0);
    wr_ctl(1'b1, 1'b1);
    send_ring(32'hB000_0002, 4'h3, 1'b0, 1'b1);
    chk("R7 empty sets status", {63'd0, resp_irq}, 64'd1);
    wr_sts(1'b1);

    // R8 pointer reset
    wp_wr = 1'b1; wp_wdata = 16'h7FFF;
    @(posedge clk); @(negedge clk);
    wp_wr = 1'b0;
    chk("R8 write without reset bit", {56'd0, wp_o}, {56'd0, exp_wp});
    wp_wr = 1'b1; wp_wdata = 16'h8000;
    @(posedge clk); @(negedge clk);
    wp_wr = 1'b0;
    exp_wp = 8'd0;
    chk("R8 pointer forced to zero", {56'd0, wp_o}, 64'd0);
    send_ring(32'hC000_0001, 4'h7, 1'b1, 1'b0);
    chk("R8 next index one", {56'd0, wp_o}, 64'd1);

    // R2 immediate, R3 discard
    do_issue();
    send_imm(32'hD00D_F00D, 4'hC);
    wr_ctl(1'b1, 1'b0);
    send_drop(32'hDEAD_0001, 4'h4);
    wr_ctl(1'b1, 1'b1);

    // random mix, covers pointer and count wrap
    for (int i = 0; i < 420; i++) begin
      int r;
      r = $urandom % 12;
      if (r == 0) begin
        do_issue();
        send_imm($urandom, 4'($urandom));
      end else if (r == 1) begin
        wr_ctl(exp_ie, 1'b0);
        send_drop($urandom, 4'($urandom));
        wr_ctl(exp_ie, 1'b1);
      end else if (r == 2) begin
        wr_ctl(1'($urandom), 1'b1);
      end else if (r == 3) begin
        wr_thr(8'(($urandom % 12) + 1));
      end else begin
        send_ring($urandom, 4'($urandom), 1'($urandom), ($urandom % 4) == 0);
      end
      if (exp_sts && ($urandom % 2) == 0) wr_sts(1'b1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule